// File: doc/BRIEF.md
# Eight-Line Prioritised Interrupt Controller

This block gathers eight interrupt request lines and presents one interrupt output to a processor. Each line owns one bit in three 8-bit registers: a pending register that records requests, a mask register that hides them, and an in-service register that records which requests the processor has accepted and not yet finished. Line 0 wins over line 1, and so on down to line 7. A request that is unmasked and pending drives the interrupt output only if no request of equal or higher priority is already in service. As a result, a more urgent request can nest on top of a less urgent one that is still being handled.

The processor accepts an interrupt with two acknowledge pulses. The first pulse moves the winning request into service. During the second pulse the block drives an 8-bit vector: a programmable 5-bit base followed by the 3-bit line number. The pending register cannot change from the start of the first pulse to the end of the second. Software uses a port with a one-bit address. Through it, software writes the mask, selects edge or level triggering and automatic end-of-interrupt, sets the vector base, and issues end-of-interrupt commands. It can also read back the mask and either the pending or the in-service register. The request lines and the acknowledge line each pass through a two-flop synchroniser, and the block works on edges of the synchronised copies.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset the pending and in-service registers are 0, the mask is 8'hFF, edge triggering is selected, automatic end-of-interrupt is off, the vector base is 0, status reads return the pending register, `int_o` is 0 and `vec_valid_o` is 0.
- R2: In edge mode a low-to-high transition on `irq_i[n]` sets pending bit n. If the line then stays high after it has been acknowledged, the bit is not set again until the line goes low and then high once more.
- R3: A pending bit whose mask bit is 1 is still recorded, but it never raises `int_o`.
- R4: `int_o` is 1 exactly when the lowest-index unmasked pending line n exists and in-service bits 0..n are all clear. Lower index means higher priority, so a higher-priority request can nest over a lower-priority one that is in service.
- R5: At the start of the first acknowledge pulse the in-service bit of the winning line is set. In edge mode that line's pending bit is cleared. In level mode the pending bit is left alone.
- R6: The pending register holds its value from the start of the first acknowledge pulse to the end of the second. An edge-mode rising edge that arrives in that window is taken in after the second pulse ends.
- R7: `vec_valid_o` is 1, and `vec_o` equals {base[4:0], line[2:0]}, only during the second acknowledge pulse. At all other times `vec_o` is 0.
- R8: When automatic end-of-interrupt is on, the end of the second pulse clears the in-service bit that this acknowledge set.
- R9: Writing a command byte with bits[7:5]=3'b001 clears the lowest-index in-service bit that is set. Bits[7:5]=3'b011 clears in-service bit number bits[2:0].
- R10: Writes with `reg_sel_i`=1 load the mask, and reads return it. Writes with `reg_sel_i`=0 are command bytes:
  - Bits[7:5]=3'b100 loads the configuration: bit0 selects level mode, bit1 turns on automatic end-of-interrupt, and bit2 makes status reads return the in-service register instead of the pending register.
  - Bits[7:5]=3'b111 loads the vector base from bits[4:0].
- R11: In level mode the pending register follows the synchronised request levels while it is not frozen, so a pending bit clears when its line drops.
- R12: If nothing is eligible when the first pulse starts, no in-service bit is set and the vector carries line number 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_i | input | 8 | Request lines, bit n is line n |
| ack_i | input | 1 | Acknowledge pulses from the processor, active high |
| reg_sel_i | input | 1 | Register select: 0 command/status, 1 mask |
| reg_wr_i | input | 1 | Write strobe for one cycle |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for the selected register |
| int_o | output | 1 | Interrupt request to the processor |
| vec_o | output | 8 | Interrupt vector, nonzero only in the second pulse |
| vec_valid_o | output | 1 | High while the second acknowledge pulse is active |

## Verification
A change on `irq_i` or `ack_i` reaches its registered effect on the third rising edge after it. That effect is the pending bit, the start or end of an acknowledge pulse, the in-service update and the vector window. `int_o` follows combinationally from those registers. A register write takes effect at the edge that samples it, and its result is readable from the next falling edge. The bench drives every input on a falling edge. It waits at least four falling edges after a request or acknowledge change before it samples any output, and one edge after a write. Each sample therefore falls after the last register on the path has updated, and before the next stimulus.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned LINES  = 8;
  localparam int unsigned IDX_W  = $clog2(LINES);
  localparam int unsigned BASE_W = LINES - IDX_W;

  typedef enum logic [1:0] {
    ACK_IDLE,
    ACK_FIRST,
    ACK_GAP,
    ACK_SECOND
  } ack_state_e;

  localparam logic [2:0] OP_EOI_ANY = 3'b001;
  localparam logic [2:0] OP_EOI_ONE = 3'b011;
  localparam logic [2:0] OP_CONFIG  = 3'b100;
  localparam logic [2:0] OP_BASE    = 3'b111;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
    end else begin
      stage_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/irq_pending.sv
module irq_pending #(
  parameter int unsigned L = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [L-1:0] lvl_i,
  input  logic         level_mode_i,
  input  logic         freeze_i,
  input  logic [L-1:0] clr_i,
  output logic [L-1:0] pend_o
);
  logic [L-1:0] prev_q, held_q, pend_q;
  logic [L-1:0] held_d, pend_d, rise;

  assign rise = lvl_i & ~prev_q;

  always_comb begin
    held_d = freeze_i ? (held_q | rise) : '0;
    if (freeze_i)          pend_d = pend_q;
    else if (level_mode_i) pend_d = lvl_i;
    else                   pend_d = (pend_q & ~clr_i) | rise | held_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      held_q <= '0;
      pend_q <= '0;
    end else begin
      prev_q <= lvl_i;
      held_q <= held_d;
      pend_q <= pend_d;
    end
  end

  assign pend_o = pend_q;

  // R6: no pending bit moves while frozen
  assert_frozen_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    freeze_i |=> $stable(pend_q));

  // R2: an edge seen outside the freeze is recorded at the next edge
  assert_rise_latched_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!freeze_i && !level_mode_i && rise != '0) |=> ((pend_q & $past(rise)) == $past(rise)));
endmodule

// File: rtl/irq_resolver.sv
module irq_resolver #(
  parameter int unsigned L = 8,
  localparam int unsigned IW = $clog2(L)
) (
  input  logic [L-1:0]  req_i,
  input  logic [L-1:0]  isr_i,
  output logic          int_o,
  output logic [IW-1:0] win_o,
  output logic          isr_any_o,
  output logic [IW-1:0] isr_top_o
);
  logic          found;
  logic          blocked;

  always_comb begin
    found     = 1'b0;
    win_o     = '0;
    isr_any_o = 1'b0;
    isr_top_o = '0;
    for (int i = L - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        found = 1'b1;
        win_o = IW'(i);
      end
      if (isr_i[i]) begin
        isr_any_o = 1'b1;
        isr_top_o = IW'(i);
      end
    end
    blocked = 1'b0;
    for (int i = 0; i < L; i++) begin
      if (IW'(i) <= win_o && isr_i[i]) blocked = 1'b1;
    end
    int_o = found && !blocked;
  end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] irq_i,
  input  logic             ack_i,
  input  logic             reg_sel_i,
  input  logic             reg_wr_i,
  input  logic [LINES-1:0] reg_wdata_i,
  output logic [LINES-1:0] reg_rdata_o,
  output logic             int_o,
  output logic [LINES-1:0] vec_o,
  output logic             vec_valid_o
);
  localparam logic [LINES-1:0] ONE = LINES'(1);

  logic [LINES:0]     sync_s;
  logic [LINES-1:0]   irq_s, pend, clr_pend;
  logic               ack_s, ack_prev_q, ack_rise, ack_fall;

  ack_state_e         state_q, state_d;
  logic [LINES-1:0]   mask_q, isr_q, isr_d, set_vec, clr_vec;
  logic               level_q, auto_q, stsel_q;
  logic [BASE_W-1:0]  base_q;
  logic [IDX_W-1:0]   line_q, line_d;
  logic               real_q, real_d;
  logic               commit, ack_done, freeze;

  logic               res_int, isr_any;
  logic [IDX_W-1:0]   res_win, isr_top;

  logic               cmd_wr, mask_wr, eoi_any, eoi_one, cfg_wr, base_wr;

  irq_sync #(.W(LINES + 1), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i({ack_i, irq_i}), .q_o(sync_s)
  );
  assign irq_s    = sync_s[LINES-1:0];
  assign ack_s    = sync_s[LINES];
  assign ack_rise = ack_s & ~ack_prev_q;
  assign ack_fall = ~ack_s & ack_prev_q;

  assign freeze = (state_q != ACK_IDLE);

  irq_pending #(.L(LINES)) u_pend (
    .clk(clk), .rst_n(rst_n), .lvl_i(irq_s), .level_mode_i(level_q),
    .freeze_i(freeze), .clr_i(clr_pend), .pend_o(pend)
  );

  irq_resolver #(.L(LINES)) u_res (
    .req_i(pend & ~mask_q), .isr_i(isr_q), .int_o(res_int), .win_o(res_win),
    .isr_any_o(isr_any), .isr_top_o(isr_top)
  );

  // register port decode
  assign cmd_wr  = reg_wr_i & ~reg_sel_i;
  assign mask_wr = reg_wr_i & reg_sel_i;
  assign eoi_any = cmd_wr && (reg_wdata_i[7:5] == OP_EOI_ANY);
  assign eoi_one = cmd_wr && (reg_wdata_i[7:5] == OP_EOI_ONE);
  assign cfg_wr  = cmd_wr && (reg_wdata_i[7:5] == OP_CONFIG);
  assign base_wr = cmd_wr && (reg_wdata_i[7:5] == OP_BASE);

  // acknowledge sequencing
  always_comb begin
    state_d  = state_q;
    commit   = 1'b0;
    ack_done = 1'b0;
    case (state_q)
      ACK_IDLE:   if (ack_rise) begin state_d = ACK_FIRST; commit = 1'b1; end
      ACK_FIRST:  if (ack_fall) state_d = ACK_GAP;
      ACK_GAP:    if (ack_rise) state_d = ACK_SECOND;
      ACK_SECOND: if (ack_fall) begin state_d = ACK_IDLE; ack_done = 1'b1; end
      default:    state_d = ACK_IDLE;
    endcase
  end

  always_comb begin
    line_d   = commit ? (res_int ? res_win : {IDX_W{1'b1}}) : line_q;
    real_d   = commit ? res_int : real_q;
    set_vec  = (commit && res_int) ? (ONE << res_win) : '0;
    clr_pend = (commit && res_int && !level_q) ? (ONE << res_win) : '0;
    clr_vec  = '0;
    if (eoi_any && isr_any)               clr_vec = clr_vec | (ONE << isr_top);
    if (eoi_one)                          clr_vec = clr_vec | (ONE << reg_wdata_i[IDX_W-1:0]);
    if (ack_done && auto_q && real_q)     clr_vec = clr_vec | (ONE << line_q);
    isr_d    = (isr_q & ~clr_vec) | set_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_prev_q <= 1'b0;
      state_q    <= ACK_IDLE;
      mask_q     <= '1;
      isr_q      <= '0;
      level_q    <= 1'b0;
      auto_q     <= 1'b0;
      stsel_q    <= 1'b0;
      base_q     <= '0;
      line_q     <= '0;
      real_q     <= 1'b0;
    end else begin
      ack_prev_q <= ack_s;
      state_q    <= state_d;
      isr_q      <= isr_d;
      line_q     <= line_d;
      real_q     <= real_d;
      if (mask_wr) mask_q <= reg_wdata_i;
      if (cfg_wr) begin
        level_q <= reg_wdata_i[0];
        auto_q  <= reg_wdata_i[1];
        stsel_q <= reg_wdata_i[2];
      end
      if (base_wr) base_q <= reg_wdata_i[BASE_W-1:0];
    end
  end

  assign int_o       = res_int;
  assign vec_valid_o = (state_q == ACK_SECOND);
  assign vec_o       = vec_valid_o ? {base_q, line_q} : '0;
  assign reg_rdata_o = reg_sel_i ? mask_q : (stsel_q ? isr_q : pend);

  // R3: the output never rises without an unmasked pending request
  assert_masked_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    int_o |-> ((pend & ~mask_q) != '0));

  // R5: accepting a live request puts its line in service
  assert_commit_in_service_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && res_int) |=> isr_q[$past(res_win)]);

  // R8: automatic end-of-interrupt retires the acknowledged line
  assert_auto_eoi_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_done && auto_q && real_q && !eoi_any && !eoi_one) |=> !isr_q[$past(line_q)]);

  // R9: non-specific end-of-interrupt retires the most urgent in-service line
  assert_eoi_any_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_any && isr_any) |=> !isr_q[$past(isr_top)]);
endmodule

// File: tb/irq_prio_ctrl_tb.sv
module irq_prio_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] irq;
  logic       ack;
  logic       reg_sel, reg_wr;
  logic [7:0] reg_wdata, reg_rdata;
  logic       int_out;
  logic [7:0] vec;
  logic       vec_valid;

  int checks = 0;
  int errs   = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  irq_prio_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .irq_i(irq), .ack_i(ack),
    .reg_sel_i(reg_sel), .reg_wr_i(reg_wr), .reg_wdata_i(reg_wdata),
    .reg_rdata_o(reg_rdata), .int_o(int_out), .vec_o(vec), .vec_valid_o(vec_valid)
  );

  // {irq, mask, expected int, expected line}
  localparam int NV = 8;
  localparam logic [19:0] TBL [NV] = '{
    {8'h01, 8'h00, 1'b1, 3'd0},
    {8'h80, 8'h00, 1'b1, 3'd7},
    {8'hA4, 8'h00, 1'b1, 3'd2},
    {8'hA4, 8'h04, 1'b1, 3'd5},
    {8'hFF, 8'hFF, 1'b0, 3'd0},
    {8'h00, 8'h00, 1'b0, 3'd0},
    {8'hF0, 8'h30, 1'b1, 3'd6},
    {8'h18, 8'h08, 1'b1, 3'd4}
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; irq = '0; ack = 1'b0; reg_sel = 1'b0; reg_wr = 1'b0; reg_wdata = '0;
    tick(3);
    rst_n = 1'b1;
    tick(2);
  endtask

  task automatic wr_reg(input logic sel, input logic [7:0] d);
    reg_sel = sel; reg_wdata = d; reg_wr = 1'b1;
    tick(1);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic sel, output logic [7:0] d);
    reg_sel = sel;
    #1;
    d = reg_rdata;
  endtask

  task automatic ack_first();
    ack = 1'b1; tick(4);
    ack = 1'b0; tick(4);
  endtask

  task automatic ack_second(output logic [7:0] v, output logic vv);
    ack = 1'b1; tick(4);
    v = vec; vv = vec_valid;
    ack = 1'b0; tick(4);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errs++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errs);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic [7:0] v;
    logic       vv;

    // R1: reset state
    do_reset();
    check("R1 int", int_out, 0);
    check("R1 vec_valid", vec_valid, 0);
    check("R1 vec", vec, 0);
    rd_reg(1'b1, d); check("R1 mask", d, 8'hFF);
    rd_reg(1'b0, d); check("R1 pending", d, 8'h00);
    wr_reg(1'b0, 8'h84);
    rd_reg(1'b0, d); check("R1 in-service", d, 8'h00);

    // R10: mask readback
    wr_reg(1'b1, 8'h5A);
    rd_reg(1'b1, d); check("R10 mask readback", d, 8'h5A);

    // R4 R7: table of priority patterns
    for (int k = 0; k < NV; k++) begin
      do_reset();
      wr_reg(1'b0, 8'hE0 | 8'h13);
      wr_reg(1'b1, TBL[k][11:4]);
      irq = TBL[k][19:12];
      tick(5);
      check($sformatf("R4 table %0d int", k), int_out, TBL[k][3]);
      if (TBL[k][3]) begin
        ack_first();
        ack_second(v, vv);
        check($sformatf("R7 table %0d vec", k), v, {5'h13, TBL[k][2:0]});
        check($sformatf("R7 table %0d valid", k), vv, 1);
      end
      irq = '0;
      tick(2);
    end

    // R2: held-high line does not re-request
    do_reset();
    wr_reg(1'b1, 8'h00);
    irq = 8'h08; tick(5);
    rd_reg(1'b0, d); check("R2 pending set", d, 8'h08);
    ack_first(); ack_second(v, vv);
    check("R2 vec", v, 8'h03);
    wr_reg(1'b0, 8'h20);
    tick(5);
    check("R2 held high int", int_out, 0);
    rd_reg(1'b0, d); check("R2 held high pending", d, 8'h00);
    irq = 8'h00; tick(3);
    irq = 8'h08; tick(5);
    check("R2 new edge int", int_out, 1);

    // R3: masked request recorded but silent
    do_reset();
    irq = 8'h40; tick(5);
    check("R3 masked int", int_out, 0);
    rd_reg(1'b0, d); check("R3 masked pending", d, 8'h40);
    wr_reg(1'b1, 8'hBF);
    check("R3 unmasked int", int_out, 1);

    // R4 R9: nesting and end-of-interrupt commands
    do_reset();
    wr_reg(1'b1, 8'h00);
    wr_reg(1'b0, 8'h84);
    irq = 8'h20; tick(5);
    ack_first(); ack_second(v, vv);
    check("R4 first vec", v, 8'h05);
    irq = 8'h24; tick(5);
    check("R4 nest int", int_out, 1);
    ack_first(); ack_second(v, vv);
    check("R4 nest vec", v, 8'h02);
    rd_reg(1'b0, d); check("R4 nest in-service", d, 8'h24);
    irq = 8'h64; tick(5);
    check("R4 lower blocked", int_out, 0);
    wr_reg(1'b0, 8'h20);
    rd_reg(1'b0, d); check("R9 non-specific", d, 8'h20);
    check("R4 still blocked", int_out, 0);
    wr_reg(1'b0, 8'h65);
    rd_reg(1'b0, d); check("R9 specific", d, 8'h00);
    check("R4 released int", int_out, 1);

    // R6 R12: freeze window and spurious acknowledge
    do_reset();
    wr_reg(1'b1, 8'h00);
    ack_first();
    irq = 8'h02; tick(5);
    rd_reg(1'b0, d); check("R6 frozen pending", d, 8'h00);
    ack_second(v, vv);
    check("R12 spurious vec", v, 8'h07);
    tick(2);
    rd_reg(1'b0, d); check("R6 taken after release", d, 8'h02);
    wr_reg(1'b0, 8'h84);
    rd_reg(1'b0, d); check("R12 no in-service", d, 8'h00);

    // R5 R11: level mode
    do_reset();
    wr_reg(1'b1, 8'h00);
    wr_reg(1'b0, 8'h81);
    irq = 8'h10; tick(5);
    check("R11 level int", int_out, 1);
    ack_first(); ack_second(v, vv);
    check("R5 level vec", v, 8'h04);
    rd_reg(1'b0, d); check("R5 level pending kept", d, 8'h10);
    wr_reg(1'b0, 8'h85);
    rd_reg(1'b0, d); check("R5 level in-service", d, 8'h10);
    irq = 8'h00; tick(5);
    wr_reg(1'b0, 8'h81);
    rd_reg(1'b0, d); check("R11 level drop", d, 8'h00);

    // R7 R8: vector window and automatic end-of-interrupt
    do_reset();
    wr_reg(1'b1, 8'h00);
    wr_reg(1'b0, 8'hFF);
    wr_reg(1'b0, 8'h86);
    irq = 8'h01; tick(5);
    ack_first();
    check("R7 gap valid", vec_valid, 0);
    check("R7 gap vec", vec, 0);
    ack_second(v, vv);
    check("R7 auto vec", v, 8'hF8);
    check("R7 auto valid", vv, 1);
    rd_reg(1'b0, d); check("R8 auto cleared", d, 8'h00);
    check("R8 int after", int_out, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errs);
    $finish;
  end
endmodule